// File: doc/BRIEF.md
# Adaptive Row Buffer Policy Controller

This block sits between a memory request scheduler and the DRAM command generator and decides, bank by bank, when an open row should be closed. It remembers which row is open in every bank, turns each accepted request into the shortest legal command sequence (a column access for a row hit, activate then access for a closed bank, precharge then activate then access for a row conflict), and spaces those commands by a fixed precharge latency and a fixed activate-to-access latency.

A two-bit mode input chooses the closing policy. Open-page mode never closes a row on its own, which favours streams with strong locality. Close-page mode precharges right after every access, which favours streams with little locality. Hybrid mode closes a row once it has likely stopped being useful: either its per-bank idle timer runs out, or it has served as many accesses as a per-bank budget allows. That budget learns from history: it grows when a row keeps getting hits after the budget was reached and shrinks when a row is closed without such a hit.

Only one command strobe is raised per clock. A new mode is adopted only after every open row has been precharged.

Top module: `rowpol_ctrl`

## Requirements
- R1: A request accepted while its bank has the same row open produces its column strobe (read when req_write_i is 0, write when 1) in the cycle right after the accepting edge, with no activate or precharge for it.
- R2: A request to a bank with no open row produces an activate in the cycle after the accepting edge and its column strobe T_RCD cycles after that activate.
- R3: A request to a bank holding a different open row produces a precharge to that bank in the cycle after the accepting edge, an activate T_RP cycles later and the column strobe T_RCD cycles after the activate.
- R4: In open-page mode (mode code 0, and also code 3) an open row is never precharged except by a row conflict or a mode change, however long the bank stays idle.
- R5: In close-page mode (mode code 1) a precharge to the same bank follows every column strobe in the very next cycle, so a repeated request to the same row needs a new activate.
- R6: In hybrid mode (mode code 2), with the budget not reached and no further request, the row is precharged IDLE_LIMIT+1 cycles after its last column strobe.
- R7: In hybrid mode, when the accesses served since the activate reach budget+1 and no request is waiting, the row is precharged in the cycle right after that access.
- R8: Each bank's budget is a 0..3 saturating value that starts at INIT_BUDGET, rises by one on a hit that arrives after the budget was reached, and falls by one when a hybrid-mode precharge closes the row without such a hit.
- R9: While mode_i differs from the mode in force, req_ready_o is low; open rows are precharged lowest bank first, T_RP+1 cycles apart, and then the new mode is adopted.
- R10: At most one of the four command strobes is high in any cycle.
- R11: During and right after reset no strobe is high, every bank is closed and req_ready_o is high when mode_i is open-page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 open-page, 1 close-page, 2 hybrid, 3 open-page |
| req_valid_i | input | 1 | Request present |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_ready_o | output | 1 | Request accepted on an edge where valid and ready are both high |
| cmd_act_o | output | 1 | Activate strobe |
| cmd_rd_o | output | 1 | Read strobe |
| cmd_wr_o | output | 1 | Write strobe |
| cmd_pre_o | output | 1 | Precharge strobe |
| cmd_bank_o | output | BANK_W | Bank of the current strobe |
| cmd_row_o | output | ROW_W | Row of the current strobe |

## Verification
The bench aims at the edges of the hybrid policy: a request arriving in the same cycle a budget-exhausted row would close (a controller that let the close win would precharge and reactivate instead of counting a hit and raising the budget), the exact expiry cycle of the idle timer (an off-by-one reload would shift the precharge), and saturation of the budget at zero. It also checks that a mode change drains open rows lowest bank first with ready held low, since a design that switched at once would leave rows open under close-page rules, and that close-page never turns a repeated row into a hit.

// File: rtl/rowpol_pkg.sv
package rowpol_pkg;

    // policy codes on mode_i
    localparam logic [1:0] MODE_OPEN   = 2'd0;
    localparam logic [1:0] MODE_CLOSE  = 2'd1;
    localparam logic [1:0] MODE_HYBRID = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE_WAIT,
        ST_ACT_WAIT,
        ST_AUTOPRE
    } fsm_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } cmd_e;

endpackage

// File: rtl/rowpol_pick.sv
// Lowest-index-first picker over a request mask.
module rowpol_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |mask_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/rowpol_bank.sv
// Per-bank row state: open flag, row, idle timer, served count and
// the adaptive access budget.
module rowpol_bank #(
    parameter int         ROW_W       = 14,
    parameter logic [7:0] IDLE_LIMIT  = 8'd20,
    parameter logic [1:0] INIT_BUDGET = 2'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             acc_i,
    input  logic             pre_i,
    input  logic             adapt_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             expire_o,
    output logic             spent_o
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [7:0]       timer;
        logic [2:0]       served;
        logic             extra;
        logic [1:0]       budget;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  reached;

    // served count has met the allowance of budget+1 accesses
    assign reached = bank_q.served >= ({1'b0, bank_q.budget} + 3'd1);

    always_comb begin
        bank_d = bank_q;
        if (act_i) begin
            bank_d.open   = 1'b1;
            bank_d.row    = row_i;
            bank_d.timer  = IDLE_LIMIT;
            bank_d.served = '0;
            bank_d.extra  = 1'b0;
        end else if (acc_i) begin
            bank_d.timer = IDLE_LIMIT;
            if (reached) begin
                bank_d.extra = 1'b1;
                if (bank_q.budget != 2'd3) bank_d.budget = bank_q.budget + 2'd1;
            end
            if (bank_q.served != 3'd7) bank_d.served = bank_q.served + 3'd1;
        end else if (pre_i) begin
            bank_d.open = 1'b0;
            if (adapt_i && !bank_q.extra && bank_q.budget != 2'd0)
                bank_d.budget = bank_q.budget - 2'd1;
        end else if (bank_q.open && bank_q.timer != 8'd0) begin
            bank_d.timer = bank_q.timer - 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q        <= '0;
            bank_q.budget <= INIT_BUDGET;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign open_o   = bank_q.open;
    assign row_o    = bank_q.row;
    assign expire_o = bank_q.open && (bank_q.timer == 8'd0);
    assign spent_o  = bank_q.open && reached;

    // R8: the budget moves by at most one step per cycle
    assert_budget_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.budget == $past(bank_q.budget)) ||
        (bank_q.budget == $past(bank_q.budget) + 2'd1) ||
        ($past(bank_q.budget) == bank_q.budget + 2'd1));

    // R10: a bank never sees an activate and a precharge together
    assert_no_act_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_i && pre_i));

    // R3: a precharge only targets an open bank
    assert_pre_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> bank_q.open);

endmodule

// File: rtl/rowpol_ctrl.sv
// Page-policy controller: one request at a time, one command per cycle.
module rowpol_ctrl
    import rowpol_pkg::*;
#(
    parameter int         NUM_BANKS   = 4,
    parameter int         ROW_W       = 14,
    parameter int         T_RP        = 3,
    parameter int         T_RCD       = 3,
    parameter logic [7:0] IDLE_LIMIT  = 8'd20,
    parameter logic [1:0] INIT_BUDGET = 2'd1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int T_MAX  = (T_RP > T_RCD) ? T_RP : T_RCD,
    localparam int CW     = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              req_valid_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic              req_write_i,
    output logic              req_ready_o,
    output logic              cmd_act_o,
    output logic              cmd_rd_o,
    output logic              cmd_wr_o,
    output logic              cmd_pre_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]  cmd_row_o
);
    typedef struct packed {
        fsm_e              st;
        logic [CW-1:0]     cnt;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              wr;
        logic              have;
        logic [1:0]        mode;
        cmd_e              cmd;
        logic [BANK_W-1:0] cbank;
        logic [ROW_W-1:0]  crow;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // per-bank state
    logic [NUM_BANKS-1:0] act_v, acc_v, pre_v, adapt_v;
    logic [NUM_BANKS-1:0] b_open, b_expire, b_spent;
    logic [ROW_W-1:0]     b_row [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        rowpol_bank #(
            .ROW_W       (ROW_W),
            .IDLE_LIMIT  (IDLE_LIMIT),
            .INIT_BUDGET (INIT_BUDGET)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_v[g]),
            .acc_i    (acc_v[g]),
            .pre_i    (pre_v[g]),
            .adapt_i  (adapt_v[g]),
            .row_i    (ctl_d.row),
            .open_o   (b_open[g]),
            .row_o    (b_row[g]),
            .expire_o (b_expire[g]),
            .spent_o  (b_spent[g])
        );
    end

    // candidate pickers: any open bank (drain), any bank due to close
    logic              open_any, close_any;
    logic [BANK_W-1:0] open_idx, close_idx;
    logic [NUM_BANKS-1:0] close_mask;

    assign close_mask = b_open & (b_expire | b_spent);

    rowpol_pick #(.N(NUM_BANKS)) u_pick_open (
        .mask_i (b_open),
        .any_o  (open_any),
        .idx_o  (open_idx)
    );

    rowpol_pick #(.N(NUM_BANKS)) u_pick_close (
        .mask_i (close_mask),
        .any_o  (close_any),
        .idx_o  (close_idx)
    );

    logic is_close, is_hybrid, req_hit;
    assign is_close  = (ctl_q.mode == MODE_CLOSE);
    assign is_hybrid = (ctl_q.mode == MODE_HYBRID);
    assign req_hit   = b_open[req_bank_i] && (b_row[req_bank_i] == req_row_i);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.cmd   = CMD_NONE;
        act_v       = '0;
        acc_v       = '0;
        pre_v       = '0;
        adapt_v     = '0;
        req_ready_o = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (mode_i != ctl_q.mode) begin
                    // drain open rows before the new policy applies
                    if (open_any) begin
                        ctl_d.cmd        = CMD_PRE;
                        ctl_d.cbank      = open_idx;
                        ctl_d.crow       = b_row[open_idx];
                        pre_v[open_idx]  = 1'b1;
                        ctl_d.have       = 1'b0;
                        ctl_d.cnt        = CW'(T_RP - 1);
                        ctl_d.st         = ST_PRE_WAIT;
                    end else begin
                        ctl_d.mode = mode_i;
                    end
                end else begin
                    req_ready_o = 1'b1;
                    if (req_valid_i) begin
                        ctl_d.bank  = req_bank_i;
                        ctl_d.row   = req_row_i;
                        ctl_d.wr    = req_write_i;
                        ctl_d.cbank = req_bank_i;
                        if (req_hit) begin
                            ctl_d.cmd          = req_write_i ? CMD_WR : CMD_RD;
                            ctl_d.crow         = req_row_i;
                            acc_v[req_bank_i]  = 1'b1;
                            ctl_d.have         = 1'b0;
                            if (is_close) ctl_d.st = ST_AUTOPRE;
                        end else if (b_open[req_bank_i]) begin
                            ctl_d.cmd           = CMD_PRE;
                            ctl_d.crow          = b_row[req_bank_i];
                            pre_v[req_bank_i]   = 1'b1;
                            adapt_v[req_bank_i] = is_hybrid;
                            ctl_d.have          = 1'b1;
                            ctl_d.cnt           = CW'(T_RP - 1);
                            ctl_d.st            = ST_PRE_WAIT;
                        end else begin
                            ctl_d.cmd          = CMD_ACT;
                            ctl_d.crow         = req_row_i;
                            act_v[req_bank_i]  = 1'b1;
                            ctl_d.have         = 1'b0;
                            ctl_d.cnt          = CW'(T_RCD - 1);
                            ctl_d.st           = ST_ACT_WAIT;
                        end
                    end else if (is_hybrid && close_any) begin
                        ctl_d.cmd          = CMD_PRE;
                        ctl_d.cbank        = close_idx;
                        ctl_d.crow         = b_row[close_idx];
                        pre_v[close_idx]   = 1'b1;
                        adapt_v[close_idx] = 1'b1;
                        ctl_d.have         = 1'b0;
                        ctl_d.cnt          = CW'(T_RP - 1);
                        ctl_d.st           = ST_PRE_WAIT;
                    end
                end
            end

            ST_PRE_WAIT: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else if (ctl_q.have) begin
                    ctl_d.cmd         = CMD_ACT;
                    ctl_d.cbank       = ctl_q.bank;
                    ctl_d.crow        = ctl_q.row;
                    act_v[ctl_q.bank] = 1'b1;
                    ctl_d.have        = 1'b0;
                    ctl_d.cnt         = CW'(T_RCD - 1);
                    ctl_d.st          = ST_ACT_WAIT;
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end

            ST_ACT_WAIT: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.cmd         = ctl_q.wr ? CMD_WR : CMD_RD;
                    ctl_d.cbank       = ctl_q.bank;
                    ctl_d.crow        = ctl_q.row;
                    acc_v[ctl_q.bank] = 1'b1;
                    ctl_d.st          = is_close ? ST_AUTOPRE : ST_IDLE;
                end
            end

            ST_AUTOPRE: begin
                ctl_d.cmd         = CMD_PRE;
                ctl_d.cbank       = ctl_q.bank;
                ctl_d.crow        = ctl_q.row;
                pre_v[ctl_q.bank] = 1'b1;
                ctl_d.have        = 1'b0;
                ctl_d.cnt         = CW'(T_RP - 1);
                ctl_d.st          = ST_PRE_WAIT;
            end

            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.cmd  <= CMD_NONE;
            ctl_q.mode <= MODE_OPEN;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_act_o  = (ctl_q.cmd == CMD_ACT);
    assign cmd_rd_o   = (ctl_q.cmd == CMD_RD);
    assign cmd_wr_o   = (ctl_q.cmd == CMD_WR);
    assign cmd_pre_o  = (ctl_q.cmd == CMD_PRE);
    assign cmd_bank_o = ctl_q.cbank;
    assign cmd_row_o  = ctl_q.crow;

    // cycles since the last visible precharge, saturating at T_RP
    logic [CW-1:0] since_pre_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    since_pre_q <= CW'(T_RP);
        else if (cmd_pre_o)            since_pre_q <= CW'(1);
        else if (since_pre_q < CW'(T_RP)) since_pre_q <= since_pre_q + 1'b1;
    end

    assert_onehot_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o}));

    assert_access_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd_o || cmd_wr_o) |-> (b_open[cmd_bank_o] && b_row[cmd_bank_o] == cmd_row_o));

    assert_pre_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act_o |-> (since_pre_q >= CW'(T_RP)));

    assert_close_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_rd_o || cmd_wr_o) && is_close) |=> cmd_pre_o);

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != ctl_q.mode) |-> !req_ready_o);

endmodule

// File: tb/sim_rowpol_ctrl.sv
`timescale 1ns/1ps
module sim_rowpol_ctrl;
    localparam int         NB     = 4;
    localparam int         RW     = 14;
    localparam int         BW     = 2;
    localparam int         TRP    = 3;
    localparam int         TRCD   = 3;
    localparam int         LIM    = 20;
    localparam int         K_ACT  = 0;
    localparam int         K_RD   = 1;
    localparam int         K_WR   = 2;
    localparam int         K_PRE  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          req_valid = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic          req_write = 1'b0;
    logic          req_ready;
    logic          c_act, c_rd, c_wr, c_pre;
    logic [BW-1:0] c_bank;
    logic [RW-1:0] c_row;

    rowpol_ctrl #(
        .NUM_BANKS (NB), .ROW_W (RW), .T_RP (TRP), .T_RCD (TRCD),
        .IDLE_LIMIT (8'(LIM)), .INIT_BUDGET (2'd1)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .mode_i (mode),
        .req_valid_i (req_valid), .req_bank_i (req_bank), .req_row_i (req_row),
        .req_write_i (req_write), .req_ready_o (req_ready),
        .cmd_act_o (c_act), .cmd_rd_o (c_rd), .cmd_wr_o (c_wr), .cmd_pre_o (c_pre),
        .cmd_bank_o (c_bank), .cmd_row_o (c_row)
    );

    always #4 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int multi_hits = 0;
    int n_ev = 0;
    int ev_kind [32];
    int ev_bank [32];
    int ev_row  [32];
    int ev_cyc  [32];

    always @(posedge clk) cyc <= cyc + 1;

    // command log, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if ((32'(c_act) + 32'(c_rd) + 32'(c_wr) + 32'(c_pre)) > 1) multi_hits++;
            if ((c_act || c_rd || c_wr || c_pre) && n_ev < 32) begin
                ev_kind[n_ev] = c_act ? K_ACT : c_rd ? K_RD : c_wr ? K_WR : K_PRE;
                ev_bank[n_ev] = int'(c_bank);
                ev_row[n_ev]  = int'(c_row);
                ev_cyc[n_ev]  = cyc;
                n_ev++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input int i, input int kind, input int bank, input int row,
                             input int c, input string tag);
        bit ok;
        n_run++;
        ok = (i < n_ev) && ev_kind[i] == kind && ev_bank[i] == bank &&
             ev_row[i] == row && ev_cyc[i] == c;
        if (!ok) begin
            n_fail++;
            if (i < n_ev)
                $display("FAIL %s event %0d actual kind=%0d bank=%0d row=%0d cyc=%0d expected kind=%0d bank=%0d row=%0d cyc=%0d",
                         tag, i, ev_kind[i], ev_bank[i], ev_row[i], ev_cyc[i], kind, bank, row, c);
            else
                $display("FAIL %s event %0d actual missing expected kind=%0d cyc=%0d", tag, i, kind, c);
        end
    endtask

    task automatic clear_log();
        @(posedge clk); #1;
        n_ev = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input int b, input int r, input bit w, output int acc);
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_row   = RW'(r);
        req_write = w;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        #1;
        chk(req_ready == 1'b0, "R9 ready low on mode change", int'(req_ready), 0);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({c_act, c_rd, c_wr, c_pre} == 4'b0, "R11 strobes in reset",
            int'({c_act, c_rd, c_wr, c_pre}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
        chk({c_act, c_rd, c_wr, c_pre} == 4'b0, "R11 strobes after reset",
            int'({c_act, c_rd, c_wr, c_pre}), 0);
    endtask

    task automatic t_open_page();
        int a;
        clear_log();
        send(0, 10, 1'b0, a);
        wait_cyc(TRCD + 3);
        expect_ev(0, K_ACT, 0, 10, a, "R2 cold activate");
        expect_ev(1, K_RD, 0, 10, a + TRCD, "R2 read after activate");
        clear_log();
        send(0, 10, 1'b1, a);
        wait_cyc(3);
        expect_ev(0, K_WR, 0, 10, a, "R1 hit write");
        chk(n_ev == 1, "R1 hit has no extra command", n_ev, 1);
        clear_log();
        wait_cyc(LIM + 20);
        chk(n_ev == 0, "R4 open row kept while idle", n_ev, 0);
        clear_log();
        send(0, 11, 1'b0, a);
        wait_cyc(TRP + TRCD + 3);
        expect_ev(0, K_PRE, 0, 10, a, "R3 conflict precharge");
        expect_ev(1, K_ACT, 0, 11, a + TRP, "R3 activate after precharge");
        expect_ev(2, K_RD, 0, 11, a + TRP + TRCD, "R3 read after activate");
    endtask

    task automatic t_mode_drain();
        int a;
        send(3, 7, 1'b0, a);
        wait_cyc(TRCD + 2);
        clear_log();
        set_mode(2'd1);
        wait_cyc(2);
        chk(n_ev == 2, "R9 drain precharge count", n_ev, 2);
        chk(n_ev >= 1 && ev_kind[0] == K_PRE && ev_bank[0] == 0, "R9 bank 0 first",
            (n_ev >= 1) ? ev_bank[0] : -1, 0);
        chk(n_ev >= 2 && ev_kind[1] == K_PRE && ev_bank[1] == 3, "R9 bank 3 second",
            (n_ev >= 2) ? ev_bank[1] : -1, 3);
        chk(n_ev >= 2 && ev_cyc[1] - ev_cyc[0] == TRP + 1, "R9 drain spacing",
            (n_ev >= 2) ? ev_cyc[1] - ev_cyc[0] : -1, TRP + 1);
    endtask

    task automatic t_close_page();
        int a, b;
        clear_log();
        send(2, 4, 1'b0, a);
        send(2, 4, 1'b1, b);
        wait_cyc(TRCD + TRP + 3);
        expect_ev(0, K_ACT, 2, 4, a, "R5 first activate");
        expect_ev(1, K_RD, 2, 4, a + TRCD, "R5 read");
        expect_ev(2, K_PRE, 2, 4, a + TRCD + 1, "R5 precharge right after access");
        expect_ev(3, K_ACT, 2, 4, b, "R5 same row needs new activate");
        expect_ev(4, K_WR, 2, 4, b + TRCD, "R5 write");
        expect_ev(5, K_PRE, 2, 4, b + TRCD + 1, "R5 precharge after write");
    endtask

    task automatic t_hybrid_timer();
        int a;
        set_mode(2'd2);
        clear_log();
        send(1, 5, 1'b0, a);
        wait_cyc(TRCD + LIM + 5);
        expect_ev(1, K_RD, 1, 5, a + TRCD, "R6 read");
        expect_ev(2, K_PRE, 1, 5, a + TRCD + LIM + 1, "R6 idle timer close");
        chk(n_ev == 3, "R6 command count", n_ev, 3);
    endtask

    task automatic t_hybrid_budget();
        int a, b, r;
        // budget 1: two accesses allowed, then close
        clear_log();
        send(2, 8, 1'b0, a);
        send(2, 8, 1'b0, b);
        wait_cyc(TRP + 3);
        r = a + TRCD;
        expect_ev(1, K_RD, 2, 8, r, "R7 first read");
        expect_ev(2, K_RD, 2, 8, r + 1, "R7 second read is a hit");
        expect_ev(3, K_PRE, 2, 8, r + 2, "R7 close after budget reached");
        // budget now 0: single access closes at once
        clear_log();
        send(2, 9, 1'b0, a);
        wait_cyc(TRCD + TRP + 3);
        expect_ev(2, K_PRE, 2, 9, a + TRCD + 1, "R8 budget decremented");
        // still 0 after another close (saturation)
        clear_log();
        send(2, 12, 1'b0, a);
        wait_cyc(TRCD + TRP + 3);
        expect_ev(2, K_PRE, 2, 12, a + TRCD + 1, "R8 budget saturates at zero");
        // hit after the budget was met raises it
        clear_log();
        send(2, 9, 1'b0, a);
        send(2, 9, 1'b1, b);
        wait_cyc(TRP + 3);
        r = a + TRCD;
        expect_ev(2, K_WR, 2, 9, r + 1, "R8 extra hit served");
        expect_ev(3, K_PRE, 2, 9, r + 2, "R8 close after extra hit");
        // budget 1 again: a single access now waits for the timer
        clear_log();
        send(2, 10, 1'b0, a);
        wait_cyc(TRCD + LIM + 5);
        expect_ev(2, K_PRE, 2, 10, a + TRCD + LIM + 1, "R8 budget incremented");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_open_page();
                t_mode_drain();
                t_close_page();
                t_hybrid_timer();
                t_hybrid_budget();
                chk(multi_hits == 0, "R10 one strobe per cycle", multi_hits, 0);
            end
            begin
                repeat (200000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule